// File: doc/BRIEF.md
# Self-Testing Watchdog Timer

This block is a watchdog with a 32-bit up-counter and a 16-bit control register. In normal operation the counter advances on every pulse of the watchdog tick. When the counter reaches the programmed time-out value, the block raises a one-cycle reset request and clears the counter. Software prevents the request by pulsing the refresh input before the limit is reached.

A functional test mode exercises the counter, the compare path and the request path. In test mode the count source changes from the watchdog tick to a fast test tick. There are two test flavours:
- **Quick test** runs the full counter against a small programmed limit.
- **Byte test** lets only one selected byte of the counter advance and compares that byte alone with the matching byte of the limit.

A sticky test-lock bit shuts test mode off until the next reset. Two control bits decide whether the watchdog keeps counting while the CPU is in wait mode or in stop mode.

Both tick inputs are single-cycle enables synchronous to `clk`. Choosing the count source is therefore an enable multiplexer, not a multiplexer on a clock.

Top module: `wdt_selftest`

## Requirements
- R1: After a synchronous reset, `ctl_rdata` reads 16'h01D3 and `rst_req` is low. In that value, bit 0 is the run enable, bit 6 allows counting in stop mode and bit 7 allows counting in wait mode.
- R2: Bits 15 and 9 always read 0, and bit 8 always reads 1, whatever is written. Bits 7:0 and 13:11 read back exactly the value last written to them.
- R3: Bit 14 (test lock) is set by writing 1 to it. Writing 0 does not clear it; only reset clears it.
- R4: Bit 10 (test enable) has the following effects:
  - When set, the counter advances only on `test_tick`, and `wd_tick` is ignored.
  - When clear, the counter advances only on `wd_tick`, and `test_tick` is ignored.
  - While bit 14 is set, or is being set by the same write, bit 10 is stored and read as 0.
- R5: In normal and quick-test operation, each accepted tick behaves as follows:
  - If the count is greater than or equal to the limit, the counter clears and `rst_req` is high for exactly the following cycle.
  - Otherwise the count increments.
  - Consequently, starting from a cleared counter, the request follows the (limit+1)-th accepted tick.
- R6: With bits 10 and 11 both set (byte test), only counter byte `bits[13:12]` advances, modulo 256. The selection codes are 0 for bits 7:0, 1 for 15:8, 2 for 23:16 and 3 for 31:24. The other counter bytes hold their value. A time-out occurs on an accepted tick when the selected counter byte equals the same byte of the limit.
- R7: Bit 11 has no effect while bit 10 is clear.
- R8: Counting is gated by the CPU low-power inputs:
  - With bit 7 clear, no tick is accepted while `cpu_wait` is high.
  - With bit 6 clear, no tick is accepted while `cpu_stop` is high.
  - With the bit set, the corresponding mode does not stop counting.
- R9: While bit 0 is clear, the counter is held at zero and `rst_req` stays low.
- R10: A `refresh` pulse clears the counter in any mode. It takes priority over a time-out tick in the same cycle, so no request follows that cycle.
- R11: A write to `tov_wdata` through `tov_we` sets the 32-bit limit used by the next accepted tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write data |
| ctl_rdata | output | 16 | Control register read value |
| tov_we | input | 1 | Time-out limit write strobe |
| tov_wdata | input | 32 | Time-out limit write data |
| wd_tick | input | 1 | Normal watchdog count enable |
| test_tick | input | 1 | Fast count enable used in test mode |
| cpu_wait | input | 1 | CPU is in wait mode |
| cpu_stop | input | 1 | CPU is in stop mode |
| refresh | input | 1 | Counter clear pulse from software |
| rst_req | output | 1 | One-cycle reset request on time-out |

## Verification
Three pairs of functions can collide in a single cycle:
- **Refresh and time-out.** The bench counts the counter up to its limit, then drives `refresh` and an accepted tick in the same cycle. The collision is judged correct when no request appears in the next cycle and a complete fresh count of limit+1 ticks is then needed before the request.
- **Low-power gating and a tick.** Ticks are applied while the CPU wait or stop input is high. The bench confirms that the enable bits alone decide whether the request follows.
- **Mode change and stored count.** A few byte-test ticks are applied, the bench switches to quick test without a refresh, and it then checks how many ticks the chosen limit needs. This shows which byte actually advanced.

// File: rtl/wdt_selftest_pkg.sv
package wdt_selftest_pkg;

  localparam int CTL_W = 16;

  // control bit positions (the byte-select field and test bits are decoded by the counter)
  localparam int B_RUN    = 0;
  localparam int B_STOPOK = 6;
  localparam int B_WAITOK = 7;
  localparam int B_ONE    = 8;
  localparam int B_TEST   = 10;
  localparam int B_BYTEM  = 11;
  localparam int B_BSEL   = 12;
  localparam int B_LOCK   = 14;

  localparam logic [CTL_W-1:0] CTL_RESET = 16'h01D3;
  // bits stored as written: 7:0 and 13:11
  localparam logic [CTL_W-1:0] CTL_PLAIN = 16'h38FF;

  typedef struct packed {
    logic       run;
    logic       stop_ok;
    logic       wait_ok;
    logic       test;
    logic       byte_mode;
    logic [1:0] bsel;
  } wdt_mode_t;

endpackage

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg
  import wdt_selftest_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] rdata,
  output wdt_mode_t        mode
);

  logic [CTL_W-1:0] plain_q;
  logic             lock_q;
  logic             test_q;
  logic             lock_nxt;

  assign lock_nxt = lock_q | wdata[B_LOCK];

  always_ff @(posedge clk) begin
    if (rst) begin
      plain_q <= CTL_RESET & CTL_PLAIN;
      lock_q  <= 1'b0;
      test_q  <= 1'b0;
    end else if (we) begin
      plain_q <= wdata & CTL_PLAIN;
      lock_q  <= lock_nxt;
      test_q  <= wdata[B_TEST] & ~lock_nxt;
    end
  end

  always_comb begin
    rdata         = plain_q;
    rdata[B_ONE]  = 1'b1;
    rdata[B_TEST] = test_q;
    rdata[B_LOCK] = lock_q;
  end

  always_comb begin
    mode.run       = plain_q[B_RUN];
    mode.stop_ok   = plain_q[B_STOPOK];
    mode.wait_ok   = plain_q[B_WAITOK];
    mode.test      = test_q;
    mode.byte_mode = test_q & plain_q[B_BYTEM];
    mode.bsel      = plain_q[B_BSEL +: 2];
  end

endmodule

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel (
  input  logic run,
  input  logic wait_ok,
  input  logic stop_ok,
  input  logic test,
  input  logic cpu_wait,
  input  logic cpu_stop,
  input  logic wd_tick,
  input  logic test_tick,
  output logic adv
);

  logic src_tick;
  logic gated;

  // count source choice is an enable mux; both ticks share clk
  assign src_tick = test ? test_tick : wd_tick;
  assign gated    = (cpu_wait & ~wait_ok) | (cpu_stop & ~stop_ok);
  assign adv      = run & ~gated & src_tick;

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 8,
  localparam int NBYTES = CNT_W / BYTE_W,
  localparam int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             adv,
  input  logic             refresh,
  input  logic             byte_mode,
  input  logic [SEL_W-1:0] bsel,
  input  logic [CNT_W-1:0] tov,
  output logic             req
);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [CNT_W-1:0]  full_inc;
  logic [NBYTES-1:0] match;
  logic              hit;

  assign full_inc = cnt_q + CNT_W'(1);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] cur;
    logic              chosen;
    assign cur      = cnt_q[b*BYTE_W +: BYTE_W];
    assign chosen   = (bsel == SEL_W'(b));
    assign match[b] = (cur == tov[b*BYTE_W +: BYTE_W]);
    always_comb begin
      if (!byte_mode)
        cnt_nxt[b*BYTE_W +: BYTE_W] = full_inc[b*BYTE_W +: BYTE_W];
      else if (chosen)
        cnt_nxt[b*BYTE_W +: BYTE_W] = cur + BYTE_W'(1);
      else
        cnt_nxt[b*BYTE_W +: BYTE_W] = cur;
    end
  end

  assign hit = byte_mode ? match[bsel] : (cnt_q >= tov);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      req   <= 1'b0;
    end else begin
      req <= 1'b0;
      if (!run || refresh) begin
        cnt_q <= '0;
      end else if (adv) begin
        if (hit) begin
          cnt_q <= '0;
          req   <= 1'b1;
        end else begin
          cnt_q <= cnt_nxt;
        end
      end
    end
  end

endmodule

// File: rtl/wdt_selftest.sv
module wdt_selftest
  import wdt_selftest_pkg::*;
#(
  parameter int               CNT_W   = 32,
  parameter int               BYTE_W  = 8,
  parameter logic [CNT_W-1:0] TOV_RST = 32'h0000_FFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [15:0]      ctl_wdata,
  output logic [15:0]      ctl_rdata,
  input  logic             tov_we,
  input  logic [CNT_W-1:0] tov_wdata,
  input  logic             wd_tick,
  input  logic             test_tick,
  input  logic             cpu_wait,
  input  logic             cpu_stop,
  input  logic             refresh,
  output logic             rst_req
);

  localparam int NBYTES = CNT_W / BYTE_W;
  localparam int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  wdt_mode_t        mode;
  logic [CNT_W-1:0] tov_q;
  logic             adv;

  always_ff @(posedge clk) begin
    if (rst)         tov_q <= TOV_RST;
    else if (tov_we) tov_q <= tov_wdata;
  end

  wdt_ctl_reg u_ctl (
    .clk   (clk),
    .rst   (rst),
    .we    (ctl_we),
    .wdata (ctl_wdata),
    .rdata (ctl_rdata),
    .mode  (mode)
  );

  wdt_tick_sel u_sel (
    .run       (mode.run),
    .wait_ok   (mode.wait_ok),
    .stop_ok   (mode.stop_ok),
    .test      (mode.test),
    .cpu_wait  (cpu_wait),
    .cpu_stop  (cpu_stop),
    .wd_tick   (wd_tick),
    .test_tick (test_tick),
    .adv       (adv)
  );

  wdt_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .run       (mode.run),
    .adv       (adv),
    .refresh   (refresh),
    .byte_mode (mode.byte_mode),
    .bsel      (SEL_W'(mode.bsel)),
    .tov       (tov_q),
    .req       (rst_req)
  );

endmodule

// File: rtl/wdt_selftest_chk.sv
module wdt_selftest_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] ctl_rdata,
  input logic        wd_tick,
  input logic        test_tick,
  input logic        cpu_wait,
  input logic        cpu_stop,
  input logic        refresh,
  input logic        rst_req
);

  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    ctl_rdata[14] |=> ctl_rdata[14]);

  p_lock_blocks_test_r4: assert property (@(posedge clk) disable iff (rst)
    ctl_rdata[14] |-> !ctl_rdata[10]);

  p_test_ignores_wd_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_rdata[10] && !test_tick) |=> !rst_req);

  p_normal_ignores_test_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctl_rdata[10] && !wd_tick) |=> !rst_req);

  p_wait_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (cpu_wait && !ctl_rdata[7]) |=> !rst_req);

  p_stop_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (cpu_stop && !ctl_rdata[6]) |=> !rst_req);

  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !ctl_rdata[0] |=> !rst_req);

  p_refresh_wins_r10: assert property (@(posedge clk) disable iff (rst)
    refresh |=> !rst_req);

endmodule

bind wdt_selftest wdt_selftest_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .ctl_rdata (ctl_rdata),
  .wd_tick   (wd_tick),
  .test_tick (test_tick),
  .cpu_wait  (cpu_wait),
  .cpu_stop  (cpu_stop),
  .refresh   (refresh),
  .rst_req   (rst_req)
);

// File: tb/wdt_selftest_tb_top.sv
module wdt_selftest_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic        tov_we = 1'b0;
  logic [31:0] tov_wdata = '0;
  logic        wd_tick = 1'b0;
  logic        test_tick = 1'b0;
  logic        cpu_wait = 1'b0;
  logic        cpu_stop = 1'b0;
  logic        refresh = 1'b0;
  logic        rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [15:0] BASE  = 16'h01D3;
  localparam logic [15:0] TEST  = 16'h0400;
  localparam logic [15:0] BYTEM = 16'h0800;
  localparam logic [15:0] LOCK  = 16'h4000;

  always #10 clk = ~clk;

  wdt_selftest dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [15:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_tov(input logic [31:0] v);
    @(negedge clk); tov_we = 1'b1; tov_wdata = v;
    @(negedge clk); tov_we = 1'b0;
  endtask

  task automatic do_refresh();
    @(negedge clk); refresh = 1'b1;
    @(negedge clk); refresh = 1'b0;
  endtask

  // n tick pulses from source src (0 = wd_tick, 1 = test_tick); reports first pulse index and count
  task automatic run(input int n, input bit src, output int first, output int npulse);
    first = 0; npulse = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (src) test_tick = 1'b1; else wd_tick = 1'b1;
      @(negedge clk);
      test_tick = 1'b0; wd_tick = 1'b0;
      if (rst_req) begin
        npulse++;
        if (first == 0) first = i;
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int f, np;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ctl reset value", ctl_rdata, 32'h01D3);
    chk("R1 rst_req low", rst_req, 0);

    // R2 read-back of fixed and plain bits
    wr_ctl(16'hBFFF);
    chk("R2 fixed bits after all-ones", ctl_rdata, 32'h3DFF);
    wr_ctl(16'h0000);
    chk("R2 fixed bits after zeros", ctl_rdata, 32'h0100);
    wr_ctl(16'h2A55);
    chk("R2 plain bit pattern", ctl_rdata, 32'h2955);
    wr_ctl(BASE);

    // R5 R11 normal mode sweep over the limit
    for (int t = 0; t < 6; t++) begin
      wr_tov(t);
      do_refresh();
      run(t + 1, 0, f, np);
      chk("R5 normal first request index", f, t + 1);
      chk("R5 normal one request", np, 1);
    end
    wr_tov(0);
    do_refresh();
    run(4, 1, f, np);
    chk("R4 test_tick ignored in normal mode", np, 0);

    // R7 byte select bit alone has no effect
    wr_ctl(BASE | BYTEM | 16'h3000);
    wr_tov(2);
    do_refresh();
    run(3, 0, f, np);
    chk("R7 bit11 without test mode", f, 3);

    // R4 R5 quick test
    wr_ctl(BASE | TEST);
    for (int t = 0; t < 5; t++) begin
      wr_tov(t);
      do_refresh();
      run(4, 0, f, np);
      chk("R4 wd_tick ignored in test mode", np, 0);
      do_refresh();
      run(t + 1, 1, f, np);
      chk("R5 quick test request index", f, t + 1);
    end

    // R6 byte test: every byte select, several byte limits
    for (int k = 0; k < 4; k++) begin
      for (int v = 0; v < 3; v++) begin
        logic [31:0] lim;
        lim = 32'hFFFF_FFFF;
        lim[k*8 +: 8] = 8'(v * 2);
        wr_ctl(BASE | TEST | BYTEM | 16'(k << 12));
        wr_tov(lim);
        do_refresh();
        run(v * 2 + 1, 1, f, np);
        chk($sformatf("R6 byte %0d limit %0d request", k, v * 2), f, v * 2 + 1);
      end
      // which byte advanced: two byte-test ticks, then quick test from that count
      begin
        logic [31:0] lim;
        lim = 32'hFFFF_FFFF;
        lim[k*8 +: 8] = 8'h80;
        wr_ctl(BASE | TEST | BYTEM | 16'(k << 12));
        wr_tov(lim);
        do_refresh();
        run(2, 1, f, np);
        wr_ctl(BASE | TEST);
        wr_tov((32'd2 << (8 * k)) + 32'd1);
        run(3, 1, f, np);
        chk($sformatf("R6 byte %0d position of advance", k), f, 2);
      end
    end

    // R8 wait and stop gating
    wr_ctl(BASE & ~16'h0080);
    wr_tov(0);
    do_refresh();
    cpu_wait = 1'b1;
    run(3, 0, f, np);
    chk("R8 wait gates when not allowed", np, 0);
    cpu_wait = 1'b0;
    run(1, 0, f, np);
    chk("R8 counts after wait ends", f, 1);
    wr_ctl(BASE);
    cpu_wait = 1'b1;
    run(1, 0, f, np);
    chk("R8 wait allowed keeps counting", f, 1);
    cpu_wait = 1'b0;
    wr_ctl(BASE & ~16'h0040);
    cpu_stop = 1'b1;
    run(3, 0, f, np);
    chk("R8 stop gates when not allowed", np, 0);
    wr_ctl(BASE);
    run(1, 0, f, np);
    chk("R8 stop allowed keeps counting", f, 1);
    cpu_stop = 1'b0;

    // R9 disable holds counter at zero
    wr_tov(3);
    do_refresh();
    run(2, 0, f, np);
    wr_ctl(BASE & ~16'h0001);
    run(6, 0, f, np);
    chk("R9 no request while disabled", np, 0);
    wr_ctl(BASE);
    run(4, 0, f, np);
    chk("R9 counter restarted from zero", f, 4);

    // R10 refresh collides with time-out tick
    do_refresh();
    run(3, 0, f, np);
    @(negedge clk); refresh = 1'b1; wd_tick = 1'b1;
    @(negedge clk); refresh = 1'b0; wd_tick = 1'b0;
    chk("R10 refresh beats time-out", rst_req, 0);
    run(4, 0, f, np);
    chk("R10 full count after refresh", f, 4);

    // R3 R4 lock stickiness
    wr_ctl(BASE | LOCK | TEST);
    chk("R3 lock set, R4 test blocked same write", ctl_rdata, 32'h41D3);
    wr_ctl(BASE | TEST);
    chk("R3 lock survives zero write, R4 test blocked", ctl_rdata, 32'h41D3);
    wr_tov(0);
    do_refresh();
    run(3, 1, f, np);
    chk("R4 locked: test_tick ignored", np, 0);
    run(1, 0, f, np);
    chk("R4 locked: normal count active", f, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R3 reset clears lock", ctl_rdata, 32'h01D3);
    wr_ctl(BASE | TEST);
    chk("R4 test enable after reset", ctl_rdata, 32'h05D3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule